// File: doc/BRIEF.md
# Bus Test Pattern Responder

This block is a read-only bus target that serves as the known-good partner of a bus liveness tester. It watches the address phase of a simple request/acknowledge bus. Two addresses are decoded. A read of either one starts a fixed handshake: an address acknowledge, a data transfer, a read acknowledge and a completion pulse. The word returned is an alternating-bit checkerboard. The two addresses return words that are bitwise complements of each other, so a data line that is stuck at 0 or 1, or two neighbouring lines that are shorted together, show up as a wrong value at the tester.

Each decoded address has its own phase sequencer, and both follow the same phase order. A new read is accepted only while both sequencers are idle. Any other address, any cycle without the read strobe, and any request that arrives while a transfer is running are ignored. While the block is not in a data phase it holds the read data bus at zero.

Top module: `pattern_target`

## Requirements
- R1: After reset, all four outputs are zero: address acknowledge, read data, read acknowledge and done.
- R2: A request is a hit when request, read strobe and a matching address are all high at one clock edge. After a hit, the block waits two cycles, and the address acknowledge is high in the third cycle after the sampling edge.
- R3: A read of the first address (parameter, default 0x0) returns 0xAAAAAAAA, where every odd bit is 1. The word is on the data bus in the 4th and 5th cycles after the hit.
- R4: A read of the second address (parameter, default 0x4) returns 0x55555555, where every even bit is 1. The timing is the same as in R3.
- R5: Address acknowledge, read acknowledge and done are each high for exactly one cycle. Read acknowledge comes two cycles after address acknowledge, and done comes one cycle after read acknowledge.
- R6: A read whose address matches neither decoded address produces no activity on any output.
- R7: A request without the read strobe, or a read strobe without a request, is ignored.
- R8: A hit that arrives while a transfer is in progress is ignored and does not change the running transfer.
- R9: The read data bus is zero in every cycle outside the data phase of R3 and R4.
- R10: The block is idle again in the cycle after done. A hit sampled in that cycle starts a new transfer, so back-to-back hits are 7 cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_req_i | input | 1 | Bus request in the address phase |
| bus_rd_i | input | 1 | Read strobe |
| bus_addr_i | input | AW (32) | Bus address |
| slv_addr_ack_o | output | 1 | Address acknowledge pulse |
| slv_rdata_o | output | DW (32) | Read data; zero outside the data phase |
| slv_rd_ack_o | output | 1 | Read acknowledge pulse |
| slv_done_o | output | 1 | Transfer complete pulse |

## Verification
The bench builds the block with its default parameters: 32-bit address and data, and decoded addresses 0x0 and 0x4. With 32-bit data, every bit of both checkerboard words can be compared. Decoded addresses this close together let the bench issue misses next to the hits: 0x8, and 0x1, which differs from a decoded address only in bit 0. They also let it alternate hits on the two sequencers, including during a running transfer and exactly at the 7-cycle back-to-back limit.

// File: rtl/pattern_target_pkg.sv
package pattern_target_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_WAIT1 = 3'd1,
    PH_WAIT2 = 3'd2,
    PH_AACK  = 3'd3,
    PH_XFER  = 3'd4,
    PH_RACK  = 3'd5,
    PH_DONE  = 3'd6
  } phase_t;

  localparam int unsigned NSLOT = 2;

  // Alternating-bit word. When lead_one is set, the odd bits are 1;
  // otherwise the even bits are 1.
  function automatic logic [63:0] alt_word(input logic lead_one);
    logic [63:0] w;
    for (int i = 0; i < 64; i++) begin
      w[i] = lead_one ? (i % 2 == 1) : (i % 2 == 0);
    end
    return w;
  endfunction

endpackage

// File: rtl/pattern_target_match.sv
module pattern_target_match #(
  parameter int unsigned     AW     = 32,
  parameter logic [AW-1:0]   ADDR_A = '0,
  parameter logic [AW-1:0]   ADDR_B = AW'(4)
) (
  input  logic                                  req,
  input  logic                                  rd,
  input  logic [AW-1:0]                         addr,
  output logic [pattern_target_pkg::NSLOT-1:0]  hit
);
  localparam int unsigned NS = pattern_target_pkg::NSLOT;
  localparam logic [AW-1:0] SLOT_ADDR [NS] = '{ADDR_A, ADDR_B};

  logic rd_cycle;
  assign rd_cycle = req & rd;

  for (genvar s = 0; s < NS; s++) begin : g_cmp
    assign hit[s] = rd_cycle && (addr == SLOT_ADDR[s]);
  end
endmodule

// File: rtl/pattern_target_seq.sv
module pattern_target_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic idle,
  output logic addr_ack,
  output logic data_en,
  output logic rd_ack,
  output logic done
);
  import pattern_target_pkg::*;

  phase_t ph, ph_nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph <= PH_IDLE;
    else        ph <= ph_nxt;
  end

  always_comb begin
    ph_nxt = ph;
    unique case (ph)
      PH_IDLE:  if (start) ph_nxt = PH_WAIT1;
      PH_WAIT1: ph_nxt = PH_WAIT2;
      PH_WAIT2: ph_nxt = PH_AACK;
      PH_AACK:  ph_nxt = PH_XFER;
      PH_XFER:  ph_nxt = PH_RACK;
      PH_RACK:  ph_nxt = PH_DONE;
      PH_DONE:  ph_nxt = PH_IDLE;
      default:  ph_nxt = PH_IDLE;
    endcase
  end

  assign idle     = (ph == PH_IDLE);
  assign addr_ack = (ph == PH_AACK);
  assign data_en  = (ph == PH_XFER) || (ph == PH_RACK);
  assign rd_ack   = (ph == PH_RACK);
  assign done     = (ph == PH_DONE);

  AST_WAIT_TWO: assert property (@(posedge clk) disable iff (!rst_n)
    (start && idle) |=> ##2 addr_ack); // R2
  AST_ACK_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    addr_ack |=> !addr_ack); // R5
  AST_RACK_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    addr_ack |=> ##1 rd_ack); // R5
  AST_DONE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ack |=> (done && !rd_ack)); // R5
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (idle && !done)); // R10
endmodule

// File: rtl/pattern_target.sv
module pattern_target #(
  parameter int unsigned   AW     = 32,
  parameter int unsigned   DW     = 32,
  parameter logic [AW-1:0] ADDR_A = '0,
  parameter logic [AW-1:0] ADDR_B = AW'(4)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_req_i,
  input  logic          bus_rd_i,
  input  logic [AW-1:0] bus_addr_i,
  output logic          slv_addr_ack_o,
  output logic [DW-1:0] slv_rdata_o,
  output logic          slv_rd_ack_o,
  output logic          slv_done_o
);
  import pattern_target_pkg::*;

  localparam int unsigned NS = NSLOT;
  localparam logic [63:0] WORD_ODD  = alt_word(1'b1);
  localparam logic [63:0] WORD_EVEN = alt_word(1'b0);
  localparam logic [DW-1:0] SLOT_WORD [NS] = '{WORD_ODD[DW-1:0], WORD_EVEN[DW-1:0]};

  logic [NS-1:0] hit, start, idle, busy, aack, den, rack, done;
  logic          all_idle;
  logic [DW-1:0] slot_data [NS];

  pattern_target_match #(.AW(AW), .ADDR_A(ADDR_A), .ADDR_B(ADDR_B)) u_match (
    .req  (bus_req_i),
    .rd   (bus_rd_i),
    .addr (bus_addr_i),
    .hit  (hit)
  );

  assign all_idle = &idle;
  assign busy     = ~idle;

  for (genvar s = 0; s < NS; s++) begin : g_slot
    assign start[s] = hit[s] & all_idle;
    pattern_target_seq u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start[s]),
      .idle     (idle[s]),
      .addr_ack (aack[s]),
      .data_en  (den[s]),
      .rd_ack   (rack[s]),
      .done     (done[s])
    );
    assign slot_data[s] = den[s] ? SLOT_WORD[s] : '0;
  end

  always_comb begin
    slv_rdata_o = '0;
    for (int s = 0; s < NS; s++) slv_rdata_o = slv_rdata_o | slot_data[s];
  end

  assign slv_addr_ack_o = |aack;
  assign slv_rd_ack_o   = |rack;
  assign slv_done_o     = |done;

  AST_ONE_PATH: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(busy)); // R8
  AST_DATA_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !(|den) |-> (slv_rdata_o == '0)); // R9
  AST_MISS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (all_idle && !(|hit)) |=> all_idle); // R6
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!all_idle && !(|done)) |=> !all_idle); // R8
endmodule

// File: tb/sim_pattern_target.sv
`timescale 1ns/1ps
module sim_pattern_target;
  localparam int AW = 32;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0, rd = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          aack, rack, done;
  logic [DW-1:0] rdata;

  always #2.5 clk = ~clk;

  pattern_target u0 (
    .clk(clk), .rst_n(rst_n),
    .bus_req_i(req), .bus_rd_i(rd), .bus_addr_i(addr),
    .slv_addr_ack_o(aack), .slv_rdata_o(rdata),
    .slv_rd_ack_o(rack), .slv_done_o(done)
  );

  typedef struct {
    logic          ack;
    logic [DW-1:0] data;
    logic          rack;
    logic          done;
    string         tag;
  } exp_t;

  exp_t exp_q[$];
  exp_t pend[$];
  int n_cmp = 0;
  int n_bad = 0;

  function automatic exp_t mk(logic a, logic [DW-1:0] d, logic r, logic dn, string t);
    exp_t e;
    e.ack = a; e.data = d; e.rack = r; e.done = dn; e.tag = t;
    return e;
  endfunction

  // Monitor: compare each cycle's outputs against the queued expectation.
  always @(negedge clk) begin
    if (rst_n && exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      n_cmp++;
      if (aack !== e.ack || rdata !== e.data || rack !== e.rack || done !== e.done) begin
        n_bad++;
        $display("FAIL %s: got ack=%0b data=%h rack=%0b done=%0b, expected ack=%0b data=%h rack=%0b done=%0b",
                 e.tag, aack, rdata, rack, done, e.ack, e.data, e.rack, e.done);
      end
    end
  end

  // Driver: drive one cycle and push the expected outputs after the next edge.
  task automatic step(input logic q, input logic r, input logic [AW-1:0] a, input string tag);
    logic is_hit;
    logic [DW-1:0] w;
    @(negedge clk);
    #1;
    req = q; rd = r; addr = a;
    is_hit = q && r && (a == 32'h0 || a == 32'h4);
    w = (a == 32'h0) ? 32'hAAAA_AAAA : 32'h5555_5555;
    if (pend.size() == 0 && is_hit) begin
      pend.push_back(mk(0, '0, 0, 0, "R2"));
      pend.push_back(mk(0, '0, 0, 0, "R2"));
      pend.push_back(mk(1, '0, 0, 0, "R2"));
      pend.push_back(mk(0, w, 0, 0, (a == 32'h0) ? "R3" : "R4"));
      pend.push_back(mk(0, w, 1, 0, "R5"));
      pend.push_back(mk(0, '0, 0, 1, "R5"));
      pend.push_back(mk(0, '0, 0, 0, "R9"));
      if (tag == "R10") pend[0].tag = "R10";
      exp_q.push_back(pend.pop_front());
    end else if (pend.size() > 0) begin
      exp_t e;
      e = pend.pop_front();
      if (is_hit) e.tag = "R8";
      exp_q.push_back(e);
    end else begin
      exp_q.push_back(mk(0, '0, 0, 0, tag));
    end
  endtask

  task automatic quiet(input int n, input string tag);
    for (int i = 0; i < n; i++) step(0, 0, '0, tag);
  endtask

  initial begin
    #(5.0 * 50000);
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_cmp++;
    if (aack !== 0 || rdata !== '0 || rack !== 0 || done !== 0) begin
      n_bad++;
      $display("FAIL R1: got ack=%0b data=%h rack=%0b done=%0b, expected all zero", aack, rdata, rack, done);
    end
    rst_n = 1'b1;
    quiet(2, "R9");
    // R3: first address
    step(1, 1, 32'h0, "R3");
    quiet(8, "R9");
    // R4: second address
    step(1, 1, 32'h4, "R4");
    quiet(8, "R9");
    // R6: misses, including a one-bit-off address
    step(1, 1, 32'h8, "R6");
    step(1, 1, 32'h1, "R6");
    step(1, 1, 32'hC, "R6");
    quiet(3, "R6");
    // R7: request without read strobe, and read strobe without request
    step(1, 0, 32'h0, "R7");
    step(0, 1, 32'h4, "R7");
    step(1, 0, 32'h4, "R7");
    quiet(3, "R7");
    // R8: hits while busy are ignored; R10: accepted right after done
    step(1, 1, 32'h0, "R3");
    for (int i = 0; i < 6; i++) step(1, 1, 32'h4, "R8");
    step(1, 1, 32'h4, "R10");
    for (int i = 0; i < 6; i++) step(1, 1, 32'h0, "R8");
    step(1, 1, 32'h0, "R10");
    quiet(9, "R9");
    @(negedge clk);
    @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule